// File: doc/BRIEF.md
# Frame Buffer Slot Arbiter

This block shares one single-port frame memory between a raster display reader and a stream of incoming 2-bit pixel results. The memory has 16-bit words, and its write mask enables whole 4-bit nibbles. The block runs at twice the pixel rate and repeats a fixed four-cycle round: a display read, a load of the word that holds the next pending pixel, a second display read, and a masked write that puts the pending pixel back into that word.

Pixel results may arrive in any cycle. A small circular buffer holds them until a round can commit one. When the buffer is full and no entry leaves in that cycle, the oldest entry is thrown away and a sticky overflow flag is raised. The memory has a synchronous read port: read data appears in the cycle after the address. The display pixel is taken from that data and held for one full pixel period of two cycles.

Top module: `fb_slot_arbiter`

## Requirements
- R1: After reset is released the round starts at the first display-read cycle and runs display read, load, display read, write, then repeats. In the two display-read cycles `mem_addr` is the word that holds the scan position.
- R2: A position (col, row) has the raster index row*H_ACTIVE+col. Its word address is that index divided by 8. Its slot s is the low 3 bits of the index, and the pixel sits in word bits [2s+1:2s].
- R3: `mem_we` is high only in the write cycle of a round. While it is high, exactly one bit of `mem_wmask` is set, bit s/2 (mask bit n enables bits [4n+3:4n]). `mem_wdata` equals the word read in that round's load cycle with bits [2s+1:2s] replaced by the new value. When `mem_we` is low the mask is zero.
- R4: In the load cycle, when any pixel is buffered, `mem_addr` is the word of the oldest buffered pixel.
- R5: A pixel is accepted in any cycle. Each round commits at most one buffered pixel, in arrival order, and the write cycle addresses the word loaded earlier in the same round.
- R6: When a pixel arrives while the buffer is full and no entry leaves in that cycle, the oldest entry is discarded and `buf_overflow` goes high from the next cycle and stays high until reset.
- R7: `pix_out` changes only on the clock edges that start a display-read cycle. The value it takes at that edge is the pixel requested in the display-read cycle two cycles before.
- R8: If `scan_active` was low in a display-read cycle, the pixel shown for that request is 00, whatever the memory returned.
- R9: During and right after reset, `pix_out` is 00, `mem_we` is 0, `mem_wmask` is 0 and `buf_overflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| px_valid | input | 1 | A new pixel result is present this cycle |
| px_col | input | 10 | Column of the new pixel |
| px_row | input | 9 | Row of the new pixel |
| px_val | input | 2 | Value of the new pixel |
| scan_active | input | 1 | The display position is inside the visible area |
| scan_col | input | 10 | Display column requested |
| scan_row | input | 9 | Display row requested |
| mem_addr | output | 16 | Frame memory word address |
| mem_wdata | output | 16 | Frame memory write data |
| mem_wmask | output | 4 | Nibble write enables, one bit per 4-bit field |
| mem_we | output | 1 | Frame memory write enable |
| mem_rdata | input | 16 | Frame memory read data, valid the cycle after the address |
| pix_out | output | 2 | Pixel value for the display |
| buf_overflow | output | 1 | Sticky flag: a buffered pixel was discarded |

## Verification
A round counter that slips shows up within one cycle, as a display address or a write enable in the wrong cycle. A slot or nibble error shows up at the first write, as a wrong mask bit or a damaged neighbouring pixel in `mem_wdata`. Damaged neighbours also appear on `pix_out` two cycles after that word is next read for display. An error in the buffer's order or count shows up at the next load cycle as a wrong address, or as `buf_overflow` one cycle after a burst that fills the buffer.

// File: rtl/fb_arb_pkg.sv
package fb_arb_pkg;

  localparam int PIX_BITS     = 2;
  localparam int WORD_BITS    = 16;
  localparam int NIB_BITS     = 4;
  localparam int PIX_PER_WORD = WORD_BITS / PIX_BITS;
  localparam int SLOT_BITS    = $clog2(PIX_PER_WORD);
  localparam int NIBBLES      = WORD_BITS / NIB_BITS;
  localparam int PIX_PER_NIB  = NIB_BITS / PIX_BITS;

  typedef logic [PIX_BITS-1:0]  pix_t;
  typedef logic [WORD_BITS-1:0] word_t;
  typedef logic [SLOT_BITS-1:0] slot_t;
  typedef logic [NIBBLES-1:0]   mask_t;

  // Fixed round: display read, load, display read, write.
  typedef enum logic [1:0] {
    PH_DISP_A = 2'd0,
    PH_LOAD   = 2'd1,
    PH_DISP_B = 2'd2,
    PH_WRITE  = 2'd3
  } phase_e;

  // Linear raster position of a pixel.
  function automatic logic [31:0] raster_index(input logic [31:0] col,
                                               input logic [31:0] row,
                                               input logic [31:0] width);
    return row * width + col;
  endfunction

  // Pixel held in slot s of a word.
  function automatic pix_t pick_pixel(input word_t w, input slot_t s);
    pix_t r;
    r = '0;
    for (int i = 0; i < PIX_PER_WORD; i++)
      if (slot_t'(i) == s) r = w[i*PIX_BITS +: PIX_BITS];
    return r;
  endfunction

  // Word with slot s replaced by p, all other slots kept.
  function automatic word_t splice_pixel(input word_t w, input slot_t s, input pix_t p);
    word_t r;
    r = w;
    for (int i = 0; i < PIX_PER_WORD; i++)
      if (slot_t'(i) == s) r[i*PIX_BITS +: PIX_BITS] = p;
    return r;
  endfunction

  // Nibble enable covering slot s.
  function automatic mask_t nibble_select(input slot_t s);
    mask_t m;
    m = '0;
    for (int n = 0; n < NIBBLES; n++)
      if (int'(s) / PIX_PER_NIB == n) m[n] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/fb_phase_gen.sv
module fb_phase_gen
  import fb_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase,
  output logic   slot_disp,
  output logic   slot_load,
  output logic   slot_grab,
  output logic   slot_write
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_DISP_A;
    else        phase <= phase_e'(phase + 2'd1);
  end

  assign slot_disp  = (phase == PH_DISP_A) || (phase == PH_DISP_B);
  assign slot_load  = (phase == PH_LOAD);
  assign slot_grab  = (phase == PH_DISP_B);
  assign slot_write = (phase == PH_WRITE);

endmodule

// File: rtl/fb_pix_buffer.sv
module fb_pix_buffer #(
  parameter  int ENTRY_W = 21,
  parameter  int DEPTH   = 4,
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [ENTRY_W-1:0] din,
  input  logic               pop,
  output logic [ENTRY_W-1:0] head,
  output logic               empty,
  output logic [CNT_W-1:0]   count,
  output logic               drop,
  output logic               overflow
);

  logic [ENTRY_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]   rd_ptr, wr_ptr;
  logic               full, do_pop, grow;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign do_pop = pop && !empty;
  assign drop   = push && full && !do_pop;
  assign grow   = push && !drop;
  assign head   = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push)           wr_ptr <= step_ptr(wr_ptr);
      if (do_pop || drop) rd_ptr <= step_ptr(rd_ptr);
      if (grow && !do_pop)      count <= count + CNT_W'(1);
      else if (!grow && do_pop) count <= count - CNT_W'(1);
      if (drop) overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/fb_disp_path.sv
module fb_disp_path
  import fb_arb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_take,
  input  logic  req_emit,
  input  slot_t req_slot,
  input  logic  req_active,
  input  word_t rdata,
  output pix_t  pix_out
);

  slot_t slot_q;
  logic  act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      act_q   <= 1'b0;
      pix_out <= '0;
    end else begin
      if (req_take) begin
        slot_q <= req_slot;
        act_q  <= req_active;
      end
      if (req_emit) pix_out <= act_q ? pick_pixel(rdata, slot_q) : '0;
    end
  end

endmodule

// File: rtl/fb_write_path.sv
module fb_write_path
  import fb_arb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              grab,
  input  logic              fire,
  input  logic              head_valid,
  input  logic [ADDR_W-1:0] head_addr,
  input  slot_t             head_slot,
  input  pix_t              head_pix,
  input  word_t             rdata,
  output logic [ADDR_W-1:0] op_addr,
  output word_t             wdata,
  output mask_t             wmask,
  output logic              we
);

  logic  op_valid;
  slot_t op_slot;
  pix_t  op_pix;
  word_t ld_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_valid <= 1'b0;
      op_addr  <= '0;
      op_slot  <= '0;
      op_pix   <= '0;
      ld_word  <= '0;
    end else begin
      if (take) begin
        op_valid <= head_valid;
        if (head_valid) begin
          op_addr <= head_addr;
          op_slot <= head_slot;
          op_pix  <= head_pix;
        end
      end else if (fire) begin
        op_valid <= 1'b0;
      end
      if (grab) ld_word <= rdata;
    end
  end

  assign we    = fire && op_valid;
  assign wdata = splice_pixel(ld_word, op_slot, op_pix);
  assign wmask = we ? nibble_select(op_slot) : '0;

endmodule

// File: rtl/fb_slot_arbiter.sv
module fb_slot_arbiter
  import fb_arb_pkg::*;
#(
  parameter  int H_ACTIVE  = 640,
  parameter  int V_ACTIVE  = 480,
  parameter  int BUF_DEPTH = 4,
  localparam int X_W       = $clog2(H_ACTIVE),
  localparam int Y_W       = $clog2(V_ACTIVE),
  localparam int LIN_W     = $clog2(H_ACTIVE * V_ACTIVE),
  localparam int ADDR_W    = LIN_W - SLOT_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 px_valid,
  input  logic [X_W-1:0]       px_col,
  input  logic [Y_W-1:0]       px_row,
  input  logic [PIX_BITS-1:0]  px_val,
  input  logic                 scan_active,
  input  logic [X_W-1:0]       scan_col,
  input  logic [Y_W-1:0]       scan_row,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [WORD_BITS-1:0] mem_wdata,
  output logic [NIBBLES-1:0]   mem_wmask,
  output logic                 mem_we,
  input  logic [WORD_BITS-1:0] mem_rdata,
  output logic [PIX_BITS-1:0]  pix_out,
  output logic                 buf_overflow
);

  localparam int ENTRY_W = ADDR_W + SLOT_BITS + PIX_BITS;
  localparam int CNT_W   = $clog2(BUF_DEPTH + 1);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    slot_t             slot;
    pix_t              pix;
  } entry_t;

  // Named internal events, observed by the bound checker.
  phase_e            phase;
  logic              slot_disp, slot_load, slot_grab, slot_write;
  logic              fifo_push, fifo_pop, fifo_drop, fifo_empty;
  logic [CNT_W-1:0]  fifo_cnt;
  logic [ENTRY_W-1:0] head_bits;
  entry_t            new_entry, head_entry;
  logic [LIN_W-1:0]  wr_lin, scan_lin;
  logic [ADDR_W-1:0] op_addr;

  assign wr_lin   = LIN_W'(raster_index(32'(px_col), 32'(px_row), 32'(H_ACTIVE)));
  assign scan_lin = LIN_W'(raster_index(32'(scan_col), 32'(scan_row), 32'(H_ACTIVE)));

  assign new_entry.addr = wr_lin[LIN_W-1:SLOT_BITS];
  assign new_entry.slot = wr_lin[SLOT_BITS-1:0];
  assign new_entry.pix  = px_val;
  assign head_entry     = head_bits;

  assign fifo_push = px_valid;
  assign fifo_pop  = slot_load;

  fb_phase_gen u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .slot_disp  (slot_disp),
    .slot_load  (slot_load),
    .slot_grab  (slot_grab),
    .slot_write (slot_write)
  );

  fb_pix_buffer #(
    .ENTRY_W (ENTRY_W),
    .DEPTH   (BUF_DEPTH)
  ) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (fifo_push),
    .din      (new_entry),
    .pop      (fifo_pop),
    .head     (head_bits),
    .empty    (fifo_empty),
    .count    (fifo_cnt),
    .drop     (fifo_drop),
    .overflow (buf_overflow)
  );

  fb_write_path #(
    .ADDR_W (ADDR_W)
  ) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (slot_load),
    .grab       (slot_grab),
    .fire       (slot_write),
    .head_valid (!fifo_empty),
    .head_addr  (head_entry.addr),
    .head_slot  (head_entry.slot),
    .head_pix   (head_entry.pix),
    .rdata      (mem_rdata),
    .op_addr    (op_addr),
    .wdata      (mem_wdata),
    .wmask      (mem_wmask),
    .we         (mem_we)
  );

  fb_disp_path u_disp (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_take   (slot_disp),
    .req_emit   (slot_load || slot_write),
    .req_slot   (scan_lin[SLOT_BITS-1:0]),
    .req_active (scan_active),
    .rdata      (mem_rdata),
    .pix_out    (pix_out)
  );

  always_comb begin
    unique case (phase)
      PH_LOAD:  mem_addr = head_entry.addr;
      PH_WRITE: mem_addr = op_addr;
      default:  mem_addr = scan_lin[LIN_W-1:SLOT_BITS];
    endcase
  end

endmodule

// File: rtl/fb_slot_arbiter_chk.sv
module fb_slot_arbiter_chk
  import fb_arb_pkg::*;
#(
  parameter int BUF_DEPTH = 4,
  parameter int CNT_W     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input phase_e           phase,
  input logic             mem_we,
  input logic [NIBBLES-1:0] mem_wmask,
  input logic [PIX_BITS-1:0] pix_out,
  input logic             buf_overflow,
  input logic             fifo_drop,
  input logic [CNT_W-1:0] fifo_cnt
);

  AST_ROUND_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WRITE) |=> (phase == PH_DISP_A)); // R1
  AST_ROUND_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DISP_A) |=> (phase == PH_LOAD)); // R1
  AST_WE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (phase == PH_WRITE)); // R3
  AST_ONE_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($countones(mem_wmask) == 1)); // R3
  AST_MASK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we |-> (mem_wmask == '0)); // R3
  AST_BUF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(BUF_DEPTH)); // R5
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_drop |=> buf_overflow); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    buf_overflow |=> buf_overflow); // R6
  AST_PIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_LOAD) || (phase == PH_WRITE)) |-> $stable(pix_out)); // R7

endmodule

bind fb_slot_arbiter fb_slot_arbiter_chk #(
  .BUF_DEPTH (BUF_DEPTH),
  .CNT_W     (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .phase        (phase),
  .mem_we       (mem_we),
  .mem_wmask    (mem_wmask),
  .pix_out      (pix_out),
  .buf_overflow (buf_overflow),
  .fifo_drop    (fifo_drop),
  .fifo_cnt     (fifo_cnt)
);

// File: tb/fb_slot_arbiter_test.sv
module fb_slot_arbiter_test;

  localparam int W = 640;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        px_valid = 1'b0;
  logic [9:0]  px_col = '0;
  logic [8:0]  px_row = '0;
  logic [1:0]  px_val = '0;
  logic        scan_active = 1'b0;
  logic [9:0]  scan_col = '0;
  logic [8:0]  scan_row = '0;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic [3:0]  mem_wmask;
  logic        mem_we;
  logic [1:0]  pix_out;
  logic        buf_overflow;

  fb_slot_arbiter uut (
    .clk(clk), .rst_n(rst_n),
    .px_valid(px_valid), .px_col(px_col), .px_row(px_row), .px_val(px_val),
    .scan_active(scan_active), .scan_col(scan_col), .scan_row(scan_row),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wmask(mem_wmask),
    .mem_we(mem_we), .mem_rdata(mem_rdata),
    .pix_out(pix_out), .buf_overflow(buf_overflow)
  );

  int checks = 0;
  int fails = 0;

  function automatic int seed_word(int a);
    return ((a * 40503) ^ 23130) & 16'hffff;
  endfunction

  // Environment memory, sampled away from the edge.
  int env_mem[int];
  int a_s, wd_s, mk_s;
  logic we_s = 1'b0;
  always @(negedge clk) begin
    #2;
    a_s = int'(mem_addr); we_s = mem_we; wd_s = int'(mem_wdata); mk_s = int'(mem_wmask);
  end
  always @(posedge clk) begin
    int cur;
    cur = env_mem.exists(a_s) ? env_mem[a_s] : seed_word(a_s);
    mem_rdata <= 16'(cur);
    if (we_s) begin
      for (int n = 0; n < 4; n++)
        if (mk_s[n]) cur = (cur & ~(15 << (4*n))) | (wd_s & (15 << (4*n)));
      env_mem[a_s] = cur;
    end
  end

  // Reference model state.
  int ref_mem[int];
  int ph = 0;
  int qw[$], qs[$], qp[$];
  bit op_v = 0;
  int op_w = 0, op_s = 0, op_p = 0, ld = 0;
  int rd_word = 0, rd_slot = 0;
  bit rd_act = 0;
  int epix = 0;
  bit eovf = 0;

  function automatic int rmem(int a);
    return ref_mem.exists(a) ? ref_mem[a] : seed_word(a);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input bit v, input int x, input int y, input int p,
                      input bit act, input int sx, input int sy);
    int sl, merged;
    px_valid = v; px_col = 10'(x); px_row = 9'(y); px_val = 2'(p);
    scan_active = act; scan_col = 10'(sx); scan_row = 9'(sy);
    #1;
    sl = sy * W + sx;
    if (ph == 0 || ph == 2) chk("R1 R2 display address", int'(mem_addr), sl / 8);
    if (ph == 1 && qw.size() > 0) chk("R4 load address", int'(mem_addr), qw[0]);
    chk("R3 write enable", int'(mem_we), (ph == 3 && op_v) ? 1 : 0);
    if (ph == 3 && op_v) begin
      merged = (ld & ~(3 << (2*op_s))) | (op_p << (2*op_s));
      chk("R5 write address", int'(mem_addr), op_w);
      chk("R3 nibble mask", int'(mem_wmask), 1 << (op_s / 2));
      chk("R3 merged data", int'(mem_wdata), merged & 16'hffff);
    end else begin
      chk("R3 idle mask", int'(mem_wmask), 0);
    end
    chk("R7 R8 display pixel", int'(pix_out), epix);
    chk("R6 overflow flag", int'(buf_overflow), int'(eovf));
    @(posedge clk);
    if (ph == 3 && op_v) begin
      ref_mem[op_w] = (ld & ~(3 << (2*op_s))) | (op_p << (2*op_s));
      op_v = 0;
    end
    if (ph == 0 || ph == 2) begin
      rd_word = rmem(sl / 8); rd_slot = sl % 8; rd_act = act;
    end
    if (ph == 1 || ph == 3) epix = rd_act ? ((rd_word >> (2*rd_slot)) & 3) : 0;
    if (ph == 2 && op_v) ld = rmem(op_w);
    if (ph == 1 && qw.size() > 0) begin
      op_v = 1; op_w = qw.pop_front(); op_s = qs.pop_front(); op_p = qp.pop_front();
    end
    if (v) begin
      qw.push_back((y * W + x) / 8); qs.push_back((y * W + x) % 8); qp.push_back(p);
      if (qw.size() > DEPTH) begin
        void'(qw.pop_front()); void'(qs.pop_front()); void'(qp.pop_front());
        eovf = 1;
      end
    end
    ph = (ph + 1) % 4;
    @(negedge clk);
  endtask

  int lf = 32'h1ace;
  function automatic int rnd();
    lf = lf * 1103515245 + 12345;
    return (lf >>> 8) & 32'h7fffff;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R9 reset pixel", int'(pix_out), 0);
    chk("R9 reset write enable", int'(mem_we), 0);
    chk("R9 reset mask", int'(mem_wmask), 0);
    chk("R9 reset overflow", int'(buf_overflow), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // Mixed writes and active scan over a small region.
    for (int c = 0; c < 800; c++) begin
      int r;
      r = rnd();
      tick((r % 5) == 0, (r >> 3) % 64, (r >> 9) % 2, (r >> 11) % 4,
           1, (c / 2) % 64, (c / 128) % 2);
    end
    // Both pixels of one nibble, then read back.
    tick(1, 16, 0, 1, 1, 0, 0);
    repeat (3) tick(0, 0, 0, 0, 1, 0, 0);
    tick(1, 17, 0, 2, 1, 0, 0);
    repeat (11) tick(0, 0, 0, 0, 1, 0, 0);
    for (int c = 0; c < 16; c++) tick(0, 0, 0, 0, 1, 16 + (c / 2) % 2, 0);
    // Burst that overflows the buffer.
    for (int c = 0; c < 24; c++) tick(1, 32 + c, 1, c % 4, 1, 32 + (c / 2), 1);
    // Blanking: reads ignored.
    for (int c = 0; c < 40; c++) begin
      int r;
      r = rnd();
      tick((r % 7) == 0, r % 64, 0, (r >> 4) % 4, 0, (c / 2) % 64, 0);
    end
    // Last pixel of the frame.
    tick(1, 639, 479, 3, 1, 0, 0);
    repeat (3) tick(0, 0, 0, 0, 1, 0, 0);
    tick(1, 632, 479, 2, 1, 0, 0);
    repeat (11) tick(0, 0, 0, 0, 1, 0, 0);
    for (int c = 0; c < 16; c++) tick(0, 0, 0, 0, 1, ((c / 2) % 2) ? 632 : 639, 479);
    repeat (20) tick(0, 0, 0, 0, 1, 5, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1 watchdog: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule